// File: doc/BRIEF.md
# Occupancy-Ranked Fetch Thread Chooser

This unit decides which hardware threads the front end of a simultaneous-multithreading core fetches from in each cycle. For every thread it keeps a count of that thread's instructions that sit between fetch and execution, meaning in decode, rename or the instruction queue. Each cycle the fetch unit reports how many instructions it delivered for each thread. The back end reports how many of each thread's instructions left for execution. A thread that is squashed is flushed.

From these counts the unit offers two fetch grants per cycle. The first goes to the eligible thread with the fewest instructions in flight before execution. The second goes to the eligible thread with the next fewest. Threads that drain their queued work quickly are therefore fed first, and a thread that clogs the queue is held back. Thread identity plays no part in issue scheduling further down the pipeline. It matters only for this choice.

The grants are combinational. They are formed from the current eligibility mask and the registered counts. The counts take that cycle's traffic at the next rising clock edge.

Top module: `icount_fetch_chooser`

## Requirements
- R1: Each cycle, a thread's count becomes its old value plus the instructions fetched for it minus the instructions that left for it.
- R2: When the number leaving exceeds the old count plus the number fetched, the count becomes 0 rather than wrapping.
- R3: When the result would exceed 2^CNT_W-1 (127 by default), the count holds at that maximum.
- R4: A per-thread fetched or leaving amount above 8 (4-bit fields, thread t at bits [4t+3:4t]) is treated as 8.
- R5: A flush bit for a thread sets its count to 0 at the next edge, overriding any fetched or leaving amount that cycle.
- R6: The first grant names the eligible thread with the lowest count. When counts are equal, the lower thread ID wins.
- R7: The second grant names the eligible thread with the lowest count once the first grant's thread is excluded, with the same tie rule. It never equals the first grant.
- R8: An ineligible thread is never granted. With no eligible thread neither grant is valid. With exactly one eligible thread only the first grant is valid.
- R9: Reset clears every count to 0.
- R10: A change in the eligibility mask alters the grants in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eligible | input | 8 | Per-thread fetch-eligible mask, bit t for thread t |
| fetch_amt | input | 32 | Instructions fetched this cycle, 4 bits per thread |
| leave_amt | input | 32 | Instructions leaving the pre-execution stages this cycle, 4 bits per thread |
| flush | input | 8 | Per-thread flush, clears that thread's count |
| g0_id | output | 3 | Thread ID of the first (least occupied) grant |
| g0_vld | output | 1 | First grant valid |
| g1_id | output | 3 | Thread ID of the second grant |
| g1_vld | output | 1 | Second grant valid |

## Verification
The bench drives a thread to the top of its count range and past it, then drains threads below zero. A design that wraps at either end would suddenly rank that thread the opposite way. Amounts of 9 to 15 are applied, and a design that does not clamp them would drift from the model by a few counts. Flushes are applied together with heavy fetch traffic, and a design that lets the traffic win would leave a nonzero count. The bench sets up equal counts, a single eligible thread and an empty mask. These expose a tie broken the wrong way, a duplicated grant, or a stray second grant.

// File: rtl/icount_pkg.sv
package icount_pkg;
    localparam int NUM_THREADS = 8;
    localparam int CNT_W       = 7;
    localparam int AMT_W       = 4;
    localparam int AMT_MAX     = 8;
    localparam int ID_W        = $clog2(NUM_THREADS);
endpackage

// File: rtl/icount_occ_counter.sv
module icount_occ_counter #(
    parameter int CNT_W   = 7,
    parameter int AMT_W   = 4,
    parameter int AMT_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [AMT_W-1:0] add_amt,
    input  logic [AMT_W-1:0] sub_amt,
    output logic [CNT_W-1:0] occ
);
    localparam int WW = CNT_W + AMT_W + 1;
    localparam logic [CNT_W-1:0] OCC_MAX = '1;
    localparam logic [AMT_W-1:0] AMT_LIM = AMT_W'(AMT_MAX);

    logic [AMT_W-1:0] add_c;
    logic [AMT_W-1:0] sub_c;
    logic [WW-1:0]    up;
    logic [WW-1:0]    diff;
    logic [CNT_W-1:0] occ_nxt;

    always_comb begin
        add_c = (add_amt > AMT_LIM) ? AMT_LIM : add_amt;
        sub_c = (sub_amt > AMT_LIM) ? AMT_LIM : sub_amt;
        up    = WW'(occ) + WW'(add_c);
        diff  = up - WW'(sub_c);
        if (flush) begin
            occ_nxt = '0;
        end else if (up < WW'(sub_c)) begin
            occ_nxt = '0;
        end else if (diff > WW'(OCC_MAX)) begin
            occ_nxt = OCC_MAX;
        end else begin
            occ_nxt = diff[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            occ <= occ_nxt;
        end
    end
endmodule

// File: rtl/icount_min_pick.sv
module icount_min_pick #(
    parameter int NUM_THREADS = 8,
    parameter int CNT_W       = 7,
    parameter int ID_W        = 3
) (
    input  logic [NUM_THREADS-1:0]       cand,
    input  logic [NUM_THREADS*CNT_W-1:0] occ_flat,
    output logic [ID_W-1:0]              pick_id,
    output logic                         pick_vld
);
    logic [CNT_W-1:0] best;

    always_comb begin
        best     = '0;
        pick_id  = '0;
        pick_vld = 1'b0;
        for (int i = 0; i < NUM_THREADS; i++) begin
            if (cand[i] && (!pick_vld || occ_flat[i*CNT_W +: CNT_W] < best)) begin
                pick_vld = 1'b1;
                best     = occ_flat[i*CNT_W +: CNT_W];
                pick_id  = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/icount_fetch_chooser.sv
module icount_fetch_chooser
    import icount_pkg::*;
#(
    parameter int NT   = NUM_THREADS,
    parameter int CW   = CNT_W,
    parameter int AW   = AMT_W,
    parameter int AMAX = AMT_MAX,
    parameter int IW   = $clog2(NT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NT-1:0]   eligible,
    input  logic [NT*AW-1:0] fetch_amt,
    input  logic [NT*AW-1:0] leave_amt,
    input  logic [NT-1:0]   flush,
    output logic [IW-1:0]   g0_id,
    output logic            g0_vld,
    output logic [IW-1:0]   g1_id,
    output logic            g1_vld
);
    logic [NT*CW-1:0] occ_flat;
    logic [NT-1:0]    excl;
    logic [NT-1:0]    cand1;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        icount_occ_counter #(
            .CNT_W   (CW),
            .AMT_W   (AW),
            .AMT_MAX (AMAX)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush[t]),
            .add_amt (fetch_amt[t*AW +: AW]),
            .sub_amt (leave_amt[t*AW +: AW]),
            .occ     (occ_flat[t*CW +: CW])
        );
    end

    icount_min_pick #(
        .NUM_THREADS (NT),
        .CNT_W       (CW),
        .ID_W        (IW)
    ) u_pick0 (
        .cand     (eligible),
        .occ_flat (occ_flat),
        .pick_id  (g0_id),
        .pick_vld (g0_vld)
    );

    always_comb begin
        excl        = '0;
        excl[g0_id] = g0_vld;
        cand1       = eligible & ~excl;
    end

    icount_min_pick #(
        .NUM_THREADS (NT),
        .CNT_W       (CW),
        .ID_W        (IW)
    ) u_pick1 (
        .cand     (cand1),
        .occ_flat (occ_flat),
        .pick_id  (g1_id),
        .pick_vld (g1_vld)
    );
endmodule

// File: rtl/icount_chk.sv
module icount_chk #(
    parameter int NT = 8,
    parameter int CW = 7,
    parameter int IW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NT-1:0]   eligible,
    input logic [NT-1:0]   flush,
    input logic [NT*CW-1:0] occ_flat,
    input logic [IW-1:0]   g0_id,
    input logic            g0_vld,
    input logic [IW-1:0]   g1_id,
    input logic            g1_vld
);
    a_r7_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (g0_vld && g1_vld) |-> (g0_id != g1_id));

    a_r8_g0_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        g0_vld |-> eligible[g0_id]);

    a_r8_g1_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        g1_vld |-> eligible[g1_id]);

    a_r8_g1_needs_g0: assert property (@(posedge clk) disable iff (!rst_n)
        g1_vld |-> g0_vld);

    a_r8_valid_count: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({g0_vld, g1_vld}) ==
         (($countones(eligible) > 1) ? 2 : $countones(eligible))));

    a_r7_order: assert property (@(posedge clk) disable iff (!rst_n)
        (g0_vld && g1_vld) |->
        (occ_flat[g0_id*CW +: CW] <= occ_flat[g1_id*CW +: CW]));

    for (genvar t = 0; t < NT; t++) begin : g_chk
        a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
            (g0_vld && eligible[t]) |->
            (occ_flat[t*CW +: CW] >= occ_flat[g0_id*CW +: CW]));

        a_r5_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
            $past(flush[t]) |-> (occ_flat[t*CW +: CW] == '0));
    end
endmodule

bind icount_fetch_chooser icount_chk #(
    .NT (NT),
    .CW (CW),
    .IW (IW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .eligible (eligible),
    .flush    (flush),
    .occ_flat (occ_flat),
    .g0_id    (g0_id),
    .g0_vld   (g0_vld),
    .g1_id    (g1_id),
    .g1_vld   (g1_vld)
);

// File: tb/icount_fetch_chooser_tb.sv
`timescale 1ns/1ps
module icount_fetch_chooser_tb;
    localparam int NT  = 8;
    localparam int MAXC = 127;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    eligible = '0;
    logic [31:0]   fetch_amt = '0;
    logic [31:0]   leave_amt = '0;
    logic [7:0]    flush = '0;
    logic [2:0]    g0_id, g1_id;
    logic          g0_vld, g1_vld;

    int model_cnt [NT];
    int fa [NT];
    int la [NT];
    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    string tag  = "R9";

    always #10 clk = ~clk;

    icount_fetch_chooser u_dut (
        .clk(clk), .rst_n(rst_n), .eligible(eligible),
        .fetch_amt(fetch_amt), .leave_amt(leave_amt), .flush(flush),
        .g0_id(g0_id), .g0_vld(g0_vld), .g1_id(g1_id), .g1_vld(g1_vld)
    );

    task automatic check();
        int e0 = -1, e1 = -1;
        for (int i = 0; i < NT; i++)
            if (eligible[i] && (e0 < 0 || model_cnt[i] < model_cnt[e0])) e0 = i;
        for (int i = 0; i < NT; i++)
            if (eligible[i] && i != e0 && (e1 < 0 || model_cnt[i] < model_cnt[e1])) e1 = i;
        vectors++;
        if (g0_vld !== (e0 >= 0) || (e0 >= 0 && int'(g0_id) != e0) ||
            g1_vld !== (e1 >= 0) || (e1 >= 0 && int'(g1_id) != e1)) begin
            errors++;
            $display("FAIL %s: got g0=%0d/%0b g1=%0d/%0b expected g0=%0d g1=%0d (-1 = none)",
                     tag, g0_id, g0_vld, g1_id, g1_vld, e0, e1);
        end
    endtask

    // Drive the current fa/la/flush/eligible, advance the model, check after the edge.
    task automatic apply(input logic [7:0] el, input logic [7:0] fl);
        eligible = el;
        flush    = fl;
        for (int i = 0; i < NT; i++) begin
            int a, s, v;
            fetch_amt[i*4 +: 4] = 4'(fa[i]);
            leave_amt[i*4 +: 4] = 4'(la[i]);
            a = (fa[i] > 8) ? 8 : fa[i];
            s = (la[i] > 8) ? 8 : la[i];
            v = model_cnt[i] + a - s;
            if (v < 0) v = 0;
            if (v > MAXC) v = MAXC;
            if (fl[i]) v = 0;
            model_cnt[i] = v;
        end
        @(negedge clk);
        check();
    endtask

    task automatic quiet();
        for (int i = 0; i < NT; i++) begin fa[i] = 0; la[i] = 0; end
    endtask

    initial begin
        quiet();
        for (int i = 0; i < NT; i++) model_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R9";
        check();                       // no eligible, all counts zero
        @(negedge clk);
        eligible = 8'hFF;
        #1 check();                    // R10: same-cycle response to the mask
        tag = "R6";                    // all zero: ties go to 0 then 1
        apply(8'hFF, 8'h00);
        // R1: load distinct counts
        tag = "R1";
        for (int i = 0; i < NT; i++) fa[i] = NT - i;
        apply(8'hFF, 8'h00);
        quiet(); la[7] = 1; fa[0] = 3;
        apply(8'hFF, 8'h00);
        // R6 ties at nonzero counts
        tag = "R6";
        quiet(); fa[6] = 1; fa[7] = 2;
        apply(8'hFF, 8'h00);
        apply(8'hC0, 8'h00);
        // R3 saturate high on thread 3
        tag = "R3";
        quiet(); fa[3] = 8;
        repeat (20) apply(8'h08 | 8'h10, 8'h00);
        quiet(); fa[3] = 8; la[3] = 1;
        apply(8'h18, 8'h00);
        // R4 over-range amounts
        tag = "R4";
        quiet(); fa[4] = 15; fa[5] = 9; la[3] = 12;
        repeat (3) apply(8'h38, 8'h00);
        // R2 drain below zero
        tag = "R2";
        quiet(); la[4] = 8; la[5] = 8; fa[5] = 2; la[0] = 15;
        repeat (6) apply(8'h31, 8'h00);
        quiet(); fa[0] = 1;
        apply(8'h31, 8'h00);
        // R5 flush against heavy traffic
        tag = "R5";
        quiet(); fa[3] = 8; la[3] = 0;
        apply(8'h0F, 8'h08);
        apply(8'h0F, 8'h00);
        quiet();
        apply(8'h0F, 8'h00);
        // R8 single and empty masks
        tag = "R8";
        apply(8'h20, 8'h00);
        apply(8'h00, 8'h00);
        apply(8'h80, 8'h00);
        // R7 second grant across random masks
        tag = "R7";
        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < NT; i++) begin
                fa[i] = $urandom_range(0, 15);
                la[i] = $urandom_range(0, 15);
            end
            apply(8'($urandom), (($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'h00));
        end
        // R10 mask changes without traffic
        tag = "R10";
        quiet();
        for (int k = 0; k < 40; k++) apply(8'($urandom), 8'h00);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule